// File: doc/BRIEF.md
# Zero-word elimination codec

This block shrinks streams of 32-bit data words by coding every all-zero word as one `0` bit. Every other word is coded as a `1` bit followed by its 32 bits. It is meant for memory regions that are mostly zero, such as static-field storage and class descriptor tables. The codes are packed, most significant bit first, into 32-bit words. The block has two independent paths, an encoder and a decoder, and each uses valid/ready handshakes on both sides.

The encoder takes words one at a time and marks the final word of a stream with a last flag. It then flushes any partial packed word with zero padding and flags the final packed word. The decoder first receives a command that gives the number of original words to rebuild. It then pulls packed words only when the code it is decoding still lacks bits. It emits one word per clock while complete codes are buffered, and it discards the pad bits that remain after the final word. This way the next command starts cleanly on the next packed word.

The encoder has two states. `ENC_FILL` accepts words while fewer than 32 coded bits are buffered, and it offers a packed word once 32 or more are buffered. `ENC_FILL -> ENC_FLUSH` is taken when the word carrying the last flag is accepted. `ENC_FLUSH -> ENC_FILL` is taken when the packed word holding the final code bit is taken. The decoder also has two states. `DEC_IDLE -> DEC_RUN` is taken when a command with a non-zero count is accepted, while a zero count leaves it in `DEC_IDLE`. `DEC_RUN -> DEC_IDLE` is taken when the word flagged last is taken, and this transition clears the bit buffer.

Top module: `zwe_codec`

## Requirements
- R1: An input word whose 32 bits are all zero adds exactly one `0` bit to the encoded bit stream.
- R2: Any other input word, including one with only some zero bytes, adds a `1` bit followed by its 32 bits from bit 31 down to bit 0.
- R3: Code bits are packed in stream order into 32-bit output words: the first bit of a stream lands in bit 31 of the first packed word, the next in bit 30, and so on.
- R4: After the word carrying `enc_in_last` is accepted, every remaining bit is emitted. The final packed word has its unused low bits at zero and is marked by `enc_out_last`, which is low on all other packed words. A stream of B code bits yields exactly ceil(B/32) packed words.
- R5: While `enc_out_valid` is high and `enc_out_ready` is low, the packed word and its last flag hold. `enc_in_ready` stays low from the cycle after the last input word is accepted until the final packed word is taken, and it is high again in the next cycle.
- R6: `dec_cmd_ready` is high only in `DEC_IDLE`. A command with count 0 produces no output and leaves the decoder idle and not requesting input.
- R7: For a command of count N, the decoder emits exactly N words equal to the original words in order, with `dec_out_last` high on the N-th word only. After that word is taken, the decoder is idle.
- R8: The decoder takes the minimum number of packed words that hold the N codes. Pad bits after the N-th code are discarded, whatever their values, and the next command starts on the following packed word.
- R9: While complete codes are buffered and `dec_out_ready` is high, one decoded word leaves every clock, whether its code is 1 or 33 bits long. With 32 zero-word codes in one packed word, 32 words leave on 32 consecutive clocks.
- R10: While `dec_out_valid` is high and `dec_out_ready` is low, the decoded word and its last flag hold, and `dec_cmd_ready` is low for as long as a command is active.
- R11: After reset, `enc_in_ready` = 1, `enc_out_valid` = 0, `dec_cmd_ready` = 1, `dec_in_ready` = 0 and `dec_out_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| enc_in_valid | input | 1 | Raw word offered to the encoder |
| enc_in_ready | output | 1 | Encoder accepts a raw word |
| enc_in_data | input | WORD_W | Raw word to encode |
| enc_in_last | input | 1 | Marks the final raw word of a stream |
| enc_out_valid | output | 1 | Packed word available |
| enc_out_ready | input | 1 | Consumer takes the packed word |
| enc_out_data | output | WORD_W | Packed code bits, first bit in the MSB |
| enc_out_last | output | 1 | Final packed word of the stream |
| dec_cmd_valid | input | 1 | Decode command offered |
| dec_cmd_ready | output | 1 | Decoder idle and accepting a command |
| dec_cmd_count | input | CNT_W | Number of original words to rebuild |
| dec_in_valid | input | 1 | Packed word offered to the decoder |
| dec_in_ready | output | 1 | Decoder needs a packed word |
| dec_in_data | input | WORD_W | Packed code bits |
| dec_out_valid | output | 1 | Decoded word available |
| dec_out_ready | input | 1 | Consumer takes the decoded word |
| dec_out_data | output | WORD_W | Decoded original word |
| dec_out_last | output | 1 | Final decoded word of the command |

## Verification
The bench builds the codec with `WORD_W` = 32 and `CNT_W` = 16. With 32-bit words, 33-bit codes start at every bit offset of a packed word as a stream goes on, so codes that straddle two packed words and flushes that end exactly on a word boundary both occur within streams of a few dozen words. A 16-bit count covers every stream length used, and a 40-word all-zero stream lets the decoder's one-word-per-clock rate be seen over a full packed word of 1-bit codes. Pad bits forced to ones, followed directly by the next stream, show that the decoder drops them.

// File: rtl/zwe_pkg.sv
package zwe_pkg;

    typedef enum logic {
        ENC_FILL  = 1'b0,
        ENC_FLUSH = 1'b1
    } enc_state_e;

    typedef enum logic {
        DEC_IDLE = 1'b0,
        DEC_RUN  = 1'b1
    } dec_state_e;

endpackage

// File: rtl/zwe_pack.sv
module zwe_pack
    import zwe_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_last,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data,
    output logic              out_last
);
    localparam int ACC_W  = 2 * WORD_W;
    localparam int FILL_W = $clog2(ACC_W + 1);
    localparam logic [FILL_W-1:0] WORD_BITS = FILL_W'(WORD_W);
    localparam logic [FILL_W-1:0] LONG_LEN  = FILL_W'(WORD_W + 1);

    enc_state_e        state_q, state_d;
    logic [ACC_W-1:0]  acc_q, acc_d;
    logic [FILL_W-1:0] fill_q, fill_d;

    logic              nonzero;
    logic [ACC_W-1:0]  code_aligned;
    logic              in_fire, out_fire;

    // a zero word contributes only a 0 flag, so its aligned pattern is all zero
    assign nonzero      = |in_data;
    assign code_aligned = {nonzero, in_data, {(WORD_W-1){1'b0}}} >> fill_q;
    assign in_fire      = in_valid  && in_ready;
    assign out_fire     = out_valid && out_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ENC_FILL;
            acc_q   <= '0;
            fill_q  <= '0;
        end else begin
            state_q <= state_d;
            acc_q   <= acc_d;
            fill_q  <= fill_d;
        end
    end

    always_comb begin
        state_d = state_q;
        acc_d   = acc_q;
        fill_d  = fill_q;
        unique case (state_q)
            ENC_FILL: begin
                if (out_fire) begin
                    acc_d  = acc_q << WORD_W;
                    fill_d = fill_q - WORD_BITS;
                end else if (in_fire) begin
                    acc_d  = acc_q | code_aligned;
                    fill_d = fill_q + (nonzero ? LONG_LEN : FILL_W'(1));
                    if (in_last) begin
                        state_d = ENC_FLUSH;
                    end
                end
            end
            ENC_FLUSH: begin
                if (out_fire) begin
                    acc_d = acc_q << WORD_W;
                    if (fill_q > WORD_BITS) begin
                        fill_d = fill_q - WORD_BITS;
                    end else begin
                        fill_d  = '0;
                        state_d = ENC_FILL;
                    end
                end
            end
        endcase
    end

    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_last  = 1'b0;
        out_data  = acc_q[ACC_W-1 -: WORD_W];
        unique case (state_q)
            ENC_FILL: begin
                in_ready  = (fill_q < WORD_BITS);
                out_valid = (fill_q >= WORD_BITS);
            end
            ENC_FLUSH: begin
                out_valid = (fill_q != '0);
                out_last  = (fill_q <= WORD_BITS);
            end
        endcase
    end

endmodule

// File: rtl/zwe_unpack.sv
module zwe_unpack
    import zwe_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [CNT_W-1:0]  cmd_count,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data,
    output logic              out_last
);
    localparam int ACC_W  = 2 * WORD_W;
    localparam int FILL_W = $clog2(ACC_W + 1);
    localparam logic [FILL_W-1:0] WORD_BITS = FILL_W'(WORD_W);
    localparam logic [FILL_W-1:0] LONG_LEN  = FILL_W'(WORD_W + 1);

    dec_state_e        state_q, state_d;
    logic [ACC_W-1:0]  bits_q, bits_d;
    logic [FILL_W-1:0] avail_q, avail_d;
    logic [CNT_W-1:0]  left_q, left_d;

    logic              head;
    logic              code_whole;
    logic              in_fire, out_fire, cmd_fire;

    assign head       = bits_q[ACC_W-1];
    // a code is complete when its flag is present and, for a flagged word, all 32 data bits too
    assign code_whole = (avail_q != '0) && (!head || (avail_q >= LONG_LEN));
    assign in_fire    = in_valid  && in_ready;
    assign out_fire   = out_valid && out_ready;
    assign cmd_fire   = cmd_valid && cmd_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DEC_IDLE;
            bits_q  <= '0;
            avail_q <= '0;
            left_q  <= '0;
        end else begin
            state_q <= state_d;
            bits_q  <= bits_d;
            avail_q <= avail_d;
            left_q  <= left_d;
        end
    end

    always_comb begin
        state_d = state_q;
        bits_d  = bits_q;
        avail_d = avail_q;
        left_d  = left_q;
        unique case (state_q)
            DEC_IDLE: begin
                if (cmd_fire && (cmd_count != '0)) begin
                    state_d = DEC_RUN;
                    left_d  = cmd_count;
                    bits_d  = '0;
                    avail_d = '0;
                end
            end
            DEC_RUN: begin
                if (out_fire) begin
                    if (left_q == CNT_W'(1)) begin
                        state_d = DEC_IDLE;
                        bits_d  = '0;
                        avail_d = '0;
                        left_d  = '0;
                    end else begin
                        bits_d  = head ? (bits_q << (WORD_W + 1)) : (bits_q << 1);
                        avail_d = avail_q - (head ? LONG_LEN : FILL_W'(1));
                        left_d  = left_q - CNT_W'(1);
                    end
                end else if (in_fire) begin
                    bits_d  = bits_q | ({in_data, {WORD_W{1'b0}}} >> avail_q);
                    avail_d = avail_q + WORD_BITS;
                end
            end
        endcase
    end

    always_comb begin
        cmd_ready = 1'b0;
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_last  = 1'b0;
        out_data  = head ? bits_q[ACC_W-2 -: WORD_W] : '0;
        unique case (state_q)
            DEC_IDLE: begin
                cmd_ready = 1'b1;
            end
            DEC_RUN: begin
                out_valid = code_whole;
                in_ready  = !code_whole;
                out_last  = (left_q == CNT_W'(1));
            end
        endcase
    end

endmodule

// File: rtl/zwe_codec.sv
module zwe_codec #(
    parameter int WORD_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enc_in_valid,
    output logic              enc_in_ready,
    input  logic [WORD_W-1:0] enc_in_data,
    input  logic              enc_in_last,
    output logic              enc_out_valid,
    input  logic              enc_out_ready,
    output logic [WORD_W-1:0] enc_out_data,
    output logic              enc_out_last,
    input  logic              dec_cmd_valid,
    output logic              dec_cmd_ready,
    input  logic [CNT_W-1:0]  dec_cmd_count,
    input  logic              dec_in_valid,
    output logic              dec_in_ready,
    input  logic [WORD_W-1:0] dec_in_data,
    output logic              dec_out_valid,
    input  logic              dec_out_ready,
    output logic [WORD_W-1:0] dec_out_data,
    output logic              dec_out_last
);

    zwe_pack #(.WORD_W(WORD_W)) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (enc_in_valid),
        .in_ready  (enc_in_ready),
        .in_data   (enc_in_data),
        .in_last   (enc_in_last),
        .out_valid (enc_out_valid),
        .out_ready (enc_out_ready),
        .out_data  (enc_out_data),
        .out_last  (enc_out_last)
    );

    zwe_unpack #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_unpack (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (dec_cmd_valid),
        .cmd_ready (dec_cmd_ready),
        .cmd_count (dec_cmd_count),
        .in_valid  (dec_in_valid),
        .in_ready  (dec_in_ready),
        .in_data   (dec_in_data),
        .out_valid (dec_out_valid),
        .out_ready (dec_out_ready),
        .out_data  (dec_out_data),
        .out_last  (dec_out_last)
    );

endmodule

// File: rtl/zwe_codec_chk.sv
module zwe_codec_chk #(
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enc_in_valid,
    input logic              enc_in_ready,
    input logic              enc_in_last,
    input logic              enc_out_valid,
    input logic              enc_out_ready,
    input logic [WORD_W-1:0] enc_out_data,
    input logic              enc_out_last,
    input logic              dec_cmd_ready,
    input logic              dec_out_valid,
    input logic              dec_out_ready,
    input logic [WORD_W-1:0] dec_out_data,
    input logic              dec_out_last
);

    p_enc_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (enc_out_valid && !enc_out_ready) |=>
            (enc_out_valid && $stable(enc_out_data) && $stable(enc_out_last)));

    p_flush_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (enc_in_valid && enc_in_ready && enc_in_last) |=> !enc_in_ready);

    p_dec_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_out_valid && !dec_out_ready) |=>
            (dec_out_valid && $stable(dec_out_data) && $stable(dec_out_last)));

    p_busy_no_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dec_out_valid |-> !dec_cmd_ready);

    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_out_valid && dec_out_ready && dec_out_last) |=> (dec_cmd_ready && !dec_out_valid));

endmodule

bind zwe_codec zwe_codec_chk #(.WORD_W(WORD_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .enc_in_valid  (enc_in_valid),
    .enc_in_ready  (enc_in_ready),
    .enc_in_last   (enc_in_last),
    .enc_out_valid (enc_out_valid),
    .enc_out_ready (enc_out_ready),
    .enc_out_data  (enc_out_data),
    .enc_out_last  (enc_out_last),
    .dec_cmd_ready (dec_cmd_ready),
    .dec_out_valid (dec_out_valid),
    .dec_out_ready (dec_out_ready),
    .dec_out_data  (dec_out_data),
    .dec_out_last  (dec_out_last)
);

// File: tb/sim_zwe_codec.sv
module sim_zwe_codec;
    localparam int W  = 32;
    localparam int CW = 16;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n;
    logic          enc_in_valid, enc_in_ready, enc_in_last;
    logic [W-1:0]  enc_in_data;
    logic          enc_out_valid, enc_out_ready, enc_out_last;
    logic [W-1:0]  enc_out_data;
    logic          dec_cmd_valid, dec_cmd_ready;
    logic [CW-1:0] dec_cmd_count;
    logic          dec_in_valid, dec_in_ready;
    logic [W-1:0]  dec_in_data;
    logic          dec_out_valid, dec_out_ready, dec_out_last;
    logic [W-1:0]  dec_out_data;

    zwe_codec #(.WORD_W(W), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .enc_in_valid(enc_in_valid), .enc_in_ready(enc_in_ready),
        .enc_in_data(enc_in_data), .enc_in_last(enc_in_last),
        .enc_out_valid(enc_out_valid), .enc_out_ready(enc_out_ready),
        .enc_out_data(enc_out_data), .enc_out_last(enc_out_last),
        .dec_cmd_valid(dec_cmd_valid), .dec_cmd_ready(dec_cmd_ready),
        .dec_cmd_count(dec_cmd_count),
        .dec_in_valid(dec_in_valid), .dec_in_ready(dec_in_ready),
        .dec_in_data(dec_in_data),
        .dec_out_valid(dec_out_valid), .dec_out_ready(dec_out_ready),
        .dec_out_data(dec_out_data), .dec_out_last(dec_out_last)
    );

    int total = 0;
    int bad   = 0;

    logic [W-1:0] src_q[$];
    logic [W-1:0] pk_q[$];
    logic [W-1:0] feed_q[$];
    logic [W-1:0] dexp_q[$];
    int fp = 0;
    int maxrun = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    // reference: bit list of codes, then packing into words, first bit at the MSB
    task automatic pack_model();
        bit bq[$];
        pk_q.delete();
        foreach (src_q[i]) begin
            if (src_q[i] == '0) begin
                bq.push_back(1'b0);
            end else begin
                bq.push_back(1'b1);
                for (int b = W-1; b >= 0; b--) bq.push_back(src_q[i][b]);
            end
        end
        while (bq.size() > 0) begin
            logic [W-1:0] w;
            w = '0;
            for (int b = W-1; b >= 0; b--) begin
                if (bq.size() > 0) w[b] = bq.pop_front();
            end
            pk_q.push_back(w);
        end
    endtask

    task automatic run_enc(input string req, input int rmode);
        int ip;
        int k;
        int sz;
        bit done;
        bit flushing;
        pack_model();
        ip = 0; k = 0; done = 0; flushing = 0; sz = src_q.size();
        while (!done) begin
            @(negedge clk);
            enc_in_valid  = (ip < sz);
            enc_in_data   = (ip < sz) ? src_q[ip] : '0;
            enc_in_last   = (ip == sz - 1);
            enc_out_ready = (rmode == 0) || ($urandom % 3 != 0);
            #1;
            if (flushing) check(enc_in_ready == 1'b0, "R5", "input blocked while flushing", W'(enc_in_ready), '0);
            if (enc_in_valid && enc_in_ready) begin
                if (enc_in_last) flushing = 1;
                ip++;
            end
            if (enc_out_valid) begin
                check(k < pk_q.size(), "R4", "no extra packed word", W'(k), W'(pk_q.size()));
                if (k < pk_q.size()) begin
                    check(enc_out_data == pk_q[k], req, "packed word", enc_out_data, pk_q[k]);
                    check(enc_out_last == (k == pk_q.size() - 1), "R4", "packed last flag",
                          W'(enc_out_last), W'(k == pk_q.size() - 1));
                end
                if (enc_out_ready) begin
                    if (enc_out_last) done = 1;
                    k++;
                end
            end
        end
        @(negedge clk);
        enc_in_valid  = 1'b0;
        enc_out_ready = 1'b0;
        #1;
        check(k == pk_q.size(), "R4", "packed word count", W'(k), W'(pk_q.size()));
        check(enc_in_ready == 1'b1, "R5", "input ready after flush", W'(enc_in_ready), 32'd1);
    endtask

    task automatic run_dec(input int count, input int need, input int rmode);
        int start_fp;
        int k;
        int run;
        bit done;
        start_fp = fp; k = 0; run = 0; maxrun = 0;
        @(negedge clk);
        dec_cmd_valid = 1'b1;
        dec_cmd_count = CW'(count);
        #1;
        check(dec_cmd_ready == 1'b1, "R6", "command accepted when idle", W'(dec_cmd_ready), 32'd1);
        @(negedge clk);
        dec_cmd_valid = 1'b0;
        done = (count == 0);
        while (!done) begin
            dec_in_valid  = (fp < feed_q.size()) && ((rmode == 0) || ($urandom % 4 != 0));
            dec_in_data   = (fp < feed_q.size()) ? feed_q[fp] : '0;
            dec_out_ready = (rmode == 0) || ($urandom % 3 != 0);
            #1;
            check(dec_cmd_ready == 1'b0, "R10", "no command while busy", W'(dec_cmd_ready), '0);
            if (dec_in_valid && dec_in_ready) fp++;
            if (dec_out_valid) begin
                run++;
                if (run > maxrun) maxrun = run;
                check(k < dexp_q.size(), "R7", "no extra decoded word", W'(k), W'(dexp_q.size()));
                if (k < dexp_q.size()) begin
                    check(dec_out_data == dexp_q[k], "R7", "decoded word", dec_out_data, dexp_q[k]);
                    check(dec_out_last == (k == count - 1), "R7", "decoded last flag",
                          W'(dec_out_last), W'(k == count - 1));
                end
                if (dec_out_ready) begin
                    if (dec_out_last) done = 1;
                    k++;
                end
            end else begin
                run = 0;
            end
            @(negedge clk);
        end
        dec_in_valid  = 1'b0;
        dec_out_ready = 1'b0;
        #1;
        check(dec_cmd_ready == 1'b1, "R10", "idle after command", W'(dec_cmd_ready), 32'd1);
        check(dec_out_valid == 1'b0 && dec_in_ready == 1'b0, "R6", "nothing pending after command",
              W'({dec_out_valid, dec_in_ready}), '0);
        check(k == count, "R7", "decoded word count", W'(k), W'(count));
        check(fp - start_fp == need, "R8", "packed words consumed", W'(fp - start_fp), W'(need));
    endtask

    task automatic stream_a();
        src_q = '{32'h0000_0000, 32'h1234_5678, 32'h0000_0000, 32'h0000_0000,
                  32'hFF00_0000, 32'h0000_00FF, 32'h00FF_0000, 32'h0000_0000,
                  32'hDEAD_BEEF, 32'h0000_0000};
    endtask

    initial begin
        #(20 * 100000);
        bad++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        enc_in_valid = 0; enc_in_data = '0; enc_in_last = 0; enc_out_ready = 0;
        dec_cmd_valid = 0; dec_cmd_count = '0; dec_in_valid = 0; dec_in_data = '0; dec_out_ready = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R11: reset state
        check(enc_in_ready == 1'b1, "R11", "enc_in_ready", W'(enc_in_ready), 32'd1);
        check(enc_out_valid == 1'b0, "R11", "enc_out_valid", W'(enc_out_valid), '0);
        check(dec_cmd_ready == 1'b1, "R11", "dec_cmd_ready", W'(dec_cmd_ready), 32'd1);
        check(dec_in_ready == 1'b0, "R11", "dec_in_ready", W'(dec_in_ready), '0);
        check(dec_out_valid == 1'b0, "R11", "dec_out_valid", W'(dec_out_valid), '0);

        // R2 and R3: mixed words, some with partial zero bytes
        stream_a();
        run_enc("R2", 0);
        foreach (pk_q[i]) feed_q.push_back(pk_q[i]);
        dexp_q = src_q;
        run_dec(src_q.size(), pk_q.size(), 1);

        // R1: 40 zero words -> 40 bits -> two packed words, second padded
        src_q.delete();
        for (int i = 0; i < 40; i++) src_q.push_back('0);
        run_enc("R1", 1);
        check(pk_q.size() == 2, "R1", "model words for 40 zero codes", W'(pk_q.size()), 32'd2);
        foreach (pk_q[i]) feed_q.push_back(pk_q[i]);
        dexp_q = src_q;
        run_dec(40, 2, 0);
        check(maxrun == 32, "R9", "consecutive decoded words from one packed word", W'(maxrun), 32'd32);

        // R3: straddling 33-bit codes at shifting offsets
        src_q = '{32'h8000_0001, 32'hFFFF_FFFF, 32'h0000_0001, 32'h7FFF_FFFE, 32'h1357_9BDF};
        run_enc("R3", 1);
        foreach (pk_q[i]) feed_q.push_back(pk_q[i]);
        dexp_q = src_q;
        run_dec(src_q.size(), pk_q.size(), 1);

        // R4: exactly 32 code bits -> one packed word that is also the last
        src_q.delete();
        for (int i = 0; i < 32; i++) src_q.push_back('0);
        run_enc("R4", 0);
        foreach (pk_q[i]) feed_q.push_back(pk_q[i]);
        dexp_q = src_q;
        run_dec(32, 1, 1);

        // R6: zero count
        run_dec(0, 0, 0);

        // R8: pad bits forced to ones, next stream follows directly
        src_q = '{32'h8000_0001};
        run_enc("R3", 0);
        pk_q[1] = pk_q[1] | 32'h7FFF_FFFF;
        foreach (pk_q[i]) feed_q.push_back(pk_q[i]);
        dexp_q = src_q;
        stream_a();
        pack_model();
        foreach (pk_q[i]) feed_q.push_back(pk_q[i]);
        run_dec(1, 2, 0);
        stream_a();
        dexp_q = src_q;
        run_dec(src_q.size(), pk_q.size(), 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule